// File: doc/BRIEF.md
# SPI Register Target with CRC-8 Protection

This block is an SPI target (mode 0: data sampled on the rising clock edge, changed on the falling edge) that gives a host single 32-bit register reads and writes. The block oversamples the serial pins with the system clock through two-flop synchronizers. Each transaction opens with a 16-bit command word, sent most significant bit first. The top bit of that word is a control flag and must be 1. Bit 13 selects a write. The low 13 bits give the register address.

A strap input selects a protected framing. In that framing a CRC-8 byte follows the command word, and a second CRC-8 byte covers the 32-bit data word in either direction. The CRC uses polynomial 0x07, starts from zero, and applies no reflection and no output inversion. A read inserts one ignored turnaround byte before the target returns data. A checksum mismatch discards the access and latches a sticky error bit. Software clears that bit by writing one to it.

Top module: `spireg_crc8`

## Requirements
- R1: After reset the error bit is 0, `spi_miso` is low, and every scratch register reads 0.
- R2: A command word whose bit 15 is 0 is ignored. A write with it changes nothing, and a read with it returns all-zero bytes.
- R3: With the strap low, a read is 2 command bytes plus 1 turnaround byte from the host, followed by 4 data bytes from the target, most significant byte first.
- R4: Address 1 is read-only and always returns 0x0283BC91. Writes to it have no effect.
- R5: Four scratch registers at addresses 0x10 to 0x13 store any 32-bit value written to them and return it on reads.
- R6: With the strap high, a read returns a fifth byte after the data: the CRC-8 (polynomial 0x07, initial value 0) of the 4 data bytes. For example, data 0x0283BC91 gives 215 and data 0x12345678 gives 28.
- R7: With the strap high, a write is the command, its CRC byte, 4 data bytes and a data CRC byte. The write takes effect only when both CRC bytes match.
- R8: A command CRC mismatch sets the error bit. The access is then dropped: a write is discarded, and a read returns all-zero bytes including the CRC byte.
- R9: A data CRC mismatch on a write sets the error bit and discards the write.
- R10: Address 9 is the status register, and its bit 0 is the error bit. Writing a 1 to bit 0 clears it, writing a 0 leaves it unchanged, and `crc_err` mirrors it.
- R11: Raising chip select before the last bit of a write aborts the transaction, and no register changes.
- R12: The strap is sampled when chip select falls. Changing it during a transaction does not change that transaction's framing.
- R13: A read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_on | input | 1 | Strap that selects CRC framing; sampled when chip select falls |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| crc_err | output | 1 | Sticky CRC error bit (status bit 0) |

## Verification
Most internal faults in this block reach the ports within one transaction. A bit counter that is off by one frames the data window wrongly. The next read then comes back shifted or carries a wrong CRC trailer, and a write lands with corrupted data. A wrong running CRC or a wrong captured strap shows as a spurious `crc_err` by the end of the command or data phase, or as a write that silently fails to land. Such a failed write is visible at the first read-back of that address. An error bit that fails to clear, or a write that commits on an abort, persists, so it shows on the next status or scratch read.

// File: rtl/spireg_crc8.sv
`timescale 1ns/1ps
module spireg_crc8 #(
  parameter logic [31:0] ID_VALUE = 32'h0283_BC91,
  parameter int N_SCRATCH = 4,
  parameter int SCRATCH_BASE = 16,
  parameter int ID_ADDR = 1,
  parameter int STAT_ADDR = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic crc_on,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic crc_err
);
  localparam int ADDR_W = 13;
  localparam logic [6:0] HDR_BITS = 7'd16;

  function automatic logic [7:0] crc8_word(input logic [31:0] w);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 31; i >= 0; i--) c = {c[6:0], 1'b0} ^ ((c[7] ^ w[i]) ? 8'h07 : 8'h00);
    return c;
  endfunction

  logic [2:0] sck_q;
  logic [1:0] cs_q, mosi_q;
  logic active_d, crc_mode, rd_go, wr_go, err;
  logic [6:0] bitcnt;
  logic [7:0] crc_r;
  logic [30:0] sh;
  logic [15:0] hdr;
  logic [ADDR_W-1:0] waddr;
  logic [31:0] wbuf;
  logic [39:0] tx_sr;
  logic [31:0] scr [N_SCRATCH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0; cs_q <= 2'b11; mosi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], spi_sclk};
      cs_q <= {cs_q[0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire active = ~cs_q[1];
  wire start = active & ~active_d;
  wire bit_in = mosi_q[1];

  wire [7:0] crc_nx = {crc_r[6:0], 1'b0} ^ ((crc_r[7] ^ bit_in) ? 8'h07 : 8'h00);
  wire [6:0] cnt_nx = (bitcnt == 7'h7F) ? bitcnt : bitcnt + 7'd1;
  wire [31:0] word_in = {sh, bit_in};
  wire [15:0] hdr_now = (bitcnt == HDR_BITS - 7'd1) ? word_in[15:0] : hdr;
  wire [6:0] p_len = crc_mode ? 7'd24 : HDR_BITS;
  wire [ADDR_W-1:0] rd_addr = hdr_now[ADDR_W-1:0];
  wire hdr_good = hdr_now[15] && (!crc_mode || crc_nx == 8'h00);
  wire at_hdr = sck_rise && cnt_nx == p_len;
  wire at_wdata = sck_rise && cnt_nx == p_len + 7'd32;
  wire at_wcrc = sck_rise && crc_mode && cnt_nx == p_len + 7'd40;
  wire wr_fire = wr_go && (crc_mode ? (at_wcrc && crc_nx == 8'h00) : at_wdata);
  wire set_err = crc_mode && ((at_hdr && crc_nx != 8'h00) || (wr_go && at_wcrc && crc_nx != 8'h00));
  wire [31:0] wr_data = crc_mode ? wbuf : word_in;
  wire unused_flag = hdr_now[14];

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (rd_addr == ADDR_W'(ID_ADDR)) rd_val = ID_VALUE;
    if (rd_addr == ADDR_W'(STAT_ADDR)) rd_val = {31'b0, err};
    for (int i = 0; i < N_SCRATCH; i++)
      if (rd_addr == ADDR_W'(SCRATCH_BASE + i)) rd_val = scr[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active_d <= 1'b0; crc_mode <= 1'b0; bitcnt <= '0; crc_r <= '0; sh <= '0;
      hdr <= '0; waddr <= '0; wbuf <= '0; tx_sr <= '0; rd_go <= 1'b0; wr_go <= 1'b0;
      err <= 1'b0;
    end else begin
      active_d <= active;
      if (start) crc_mode <= crc_on;
      if (!active) begin
        bitcnt <= '0; crc_r <= '0; rd_go <= 1'b0; wr_go <= 1'b0; tx_sr <= '0;
      end else begin
        if (sck_rise) begin
          bitcnt <= cnt_nx;
          sh <= word_in[30:0];
          crc_r <= (cnt_nx == p_len) ? 8'h00 : crc_nx;
          if (cnt_nx == HDR_BITS) hdr <= hdr_now;
          if (at_hdr) begin
            rd_go <= hdr_good & ~hdr_now[13];
            wr_go <= hdr_good & hdr_now[13];
            waddr <= rd_addr;
            if (hdr_good && !hdr_now[13]) tx_sr <= {rd_val, crc8_word(rd_val)};
          end
          if (at_wdata) wbuf <= word_in;
        end
        if (sck_fall && rd_go && bitcnt >= p_len + 7'd9) tx_sr <= {tx_sr[38:0], 1'b0};
      end
      if (set_err) err <= 1'b1;
      else if (wr_fire && waddr == ADDR_W'(STAT_ADDR) && wr_data[0]) err <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < N_SCRATCH; i++) scr[i] <= '0;
    end else begin
      for (int i = 0; i < N_SCRATCH; i++)
        if (wr_fire && waddr == ADDR_W'(SCRATCH_BASE + i)) scr[i] <= wr_data;
    end

  assign spi_miso = rd_go & tx_sr[39];
  assign crc_err = err;
endmodule

// File: rtl/spireg_crc8_chk.sv
`timescale 1ns/1ps
module spireg_crc8_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_miso,
  input logic err,
  input logic active,
  input logic crc_mode,
  input logic [6:0] bitcnt,
  input logic wr_fire,
  input logic set_err
);
  // R1
  miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) |-> !spi_miso);
  // R3
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> bitcnt == 7'd0);
  // R8
  err_needs_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> crc_mode);
  // R9
  no_commit_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |-> !wr_fire);
  // R10
  clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(wr_fire));
  // R11
  commit_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> active);
  // R12
  mode_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) && $past(active, 2) |-> $stable(crc_mode));
endmodule

bind spireg_crc8 spireg_crc8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .err(err),
  .active(active), .crc_mode(crc_mode), .bitcnt(bitcnt), .wr_fire(wr_fire), .set_err(set_err)
);

// File: tb/sim_spireg_crc8.sv
`timescale 1ns/1ps
module sim_spireg_crc8;
  localparam time HALF = 64ns;
  localparam logic [31:0] ID = 32'h0283_BC91;

  logic clk = 0, rst_n = 0, crc_on = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic flip_mode = 0, finished = 0;
  wire miso, err;
  always #4 clk = ~clk;

  spireg_crc8 u0 (.clk(clk), .rst_n(rst_n), .crc_on(crc_on), .spi_sclk(sclk),
    .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso), .crc_err(err));

  int checks = 0, errors = 0;
  logic [7:0] txb [16];
  logic [7:0] rxb [16];
  logic [39:0] exp_q [$];
  string tag_q [$];
  logic [39:0] act_w;
  event got;

  function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int k = 0; k < 8; k++) r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    return r;
  endfunction

  function automatic logic [7:0] crc_w(input logic [31:0] w);
    return crc_byte(crc_byte(crc_byte(crc_byte(8'h00, w[31:24]), w[23:16]), w[15:8]), w[7:0]);
  endfunction

  function automatic logic [7:0] crc_h(input logic [15:0] h);
    return crc_byte(crc_byte(8'h00, h[15:8]), h[7:0]);
  endfunction

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  initial forever begin
    @(got);
    check(tag_q.pop_front(), act_w, exp_q.pop_front());
  end

  task automatic shift_out(input int nbytes, input int stop_bit);
    for (int i = 0; i < 16; i++) rxb[i] = 8'h00;
    cs_n = 0; #HALF;
    for (int i = 0; i < nbytes * 8; i++) begin
      if (i == stop_bit) break;
      mosi = txb[i / 8][7 - (i % 8)];
      #HALF;
      rxb[i / 8][7 - (i % 8)] = miso;
      sclk = 1;
      if (i == 0 && flip_mode) crc_on = ~crc_on;
      #HALF; sclk = 0;
    end
    #HALF; cs_n = 1; mosi = 0; #(4 * HALF);
  endtask

  task automatic rd(input logic [15:0] h, input logic crc, input logic bad_h,
                    input logic [31:0] expd, input string tag);
    int p;
    crc_on = crc;
    for (int i = 0; i < 16; i++) txb[i] = 8'h00;
    txb[0] = h[15:8]; txb[1] = h[7:0]; p = 2;
    if (crc) begin txb[2] = crc_h(h) ^ (bad_h ? 8'h5A : 8'h00); p = 3; end
    exp_q.push_back({expd, crc ? crc_w(expd) : 8'h00});
    tag_q.push_back(tag);
    shift_out(p + 5 + (crc ? 1 : 0), 1000);
    act_w = {rxb[p + 1], rxb[p + 2], rxb[p + 3], rxb[p + 4], crc ? rxb[p + 5] : 8'h00};
    -> got; #1;
  endtask

  task automatic wr(input logic [15:0] h, input logic [31:0] d, input logic crc,
                    input int bad, input int stop_bit);
    int p;
    crc_on = crc;
    for (int i = 0; i < 16; i++) txb[i] = 8'h00;
    txb[0] = h[15:8]; txb[1] = h[7:0]; p = 2;
    if (crc) begin txb[2] = crc_h(h) ^ (bad == 1 ? 8'h21 : 8'h00); p = 3; end
    txb[p] = d[31:24]; txb[p + 1] = d[23:16]; txb[p + 2] = d[15:8]; txb[p + 3] = d[7:0];
    if (crc) txb[p + 4] = crc_w(d) ^ (bad == 2 ? 8'h80 : 8'h00);
    shift_out(p + 4 + (crc ? 1 : 0), stop_bit);
  endtask

  task automatic chk_err(input logic e, input string tag);
    check(tag, {39'b0, err}, {39'b0, e});
  endtask

  initial begin
    #(200000 * 8ns);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk_err(0, "R1 err after reset");
    check("R1 miso after reset", {39'b0, miso}, 40'h0);
    rd(16'h8010, 0, 0, 32'h0, "R1 scratch reset value");
    rd(16'h8001, 0, 0, ID, "R3 R4 plain id read");
    rd(16'h8001, 1, 0, ID, "R6 id read with crc trailer 215");
    check("R6 trailer vector", {32'h0, crc_w(ID)}, {32'h0, 8'd215});
    wr(16'hA010, 32'hA5A5_0F0F, 0, 0, 1000);
    rd(16'h8010, 0, 0, 32'hA5A5_0F0F, "R5 scratch plain write");
    wr(16'hA013, 32'h1234_5678, 1, 0, 1000);
    rd(16'h8013, 1, 0, 32'h1234_5678, "R7 scratch crc write");
    wr(16'hA001, 32'hFFFF_FFFF, 0, 0, 1000);
    rd(16'h8001, 0, 0, ID, "R4 id read-only");
    rd(16'h8055, 0, 0, 32'h0, "R13 unmapped");
    wr(16'h2010, 32'h1111_1111, 0, 0, 1000);
    rd(16'h8010, 0, 0, 32'hA5A5_0F0F, "R2 control clear write ignored");
    rd(16'h0001, 0, 0, 32'h0, "R2 control clear read");
    chk_err(0, "R2 no error");
    wr(16'hA011, 32'hDEAD_BEEF, 1, 1, 1000);
    chk_err(1, "R8 header crc error");
    rd(16'h8011, 1, 0, 32'h0, "R8 write discarded");
    wr(16'hA009, 32'h0, 0, 0, 1000);
    chk_err(1, "R10 write zero keeps");
    rd(16'h8009, 1, 0, 32'h1, "R10 status read");
    wr(16'hA009, 32'h1, 0, 0, 1000);
    chk_err(0, "R10 write one clears");
    wr(16'hA011, 32'hCAFE_F00D, 1, 2, 1000);
    chk_err(1, "R9 data crc error");
    rd(16'h8011, 0, 0, 32'h0, "R9 write discarded");
    wr(16'hA009, 32'h1, 1, 0, 1000);
    chk_err(0, "R7 R10 crc clear");
    rd(16'h8010, 1, 1, 32'h0, "R8 bad header read zeros");
    chk_err(1, "R8 read header error");
    wr(16'hA009, 32'h1, 0, 0, 1000);
    wr(16'hA012, 32'h7777_7777, 0, 0, 40);
    rd(16'h8012, 0, 0, 32'h0, "R11 aborted write");
    chk_err(0, "R11 no error");
    flip_mode = 1;
    wr(16'hA012, 32'h0BAD_C0DE, 0, 0, 1000);
    flip_mode = 0;
    rd(16'h8012, 0, 0, 32'h0BAD_C0DE, "R12 plain framing kept");
    flip_mode = 1;
    wr(16'hA011, 32'h5EED_1234, 1, 0, 1000);
    flip_mode = 0;
    rd(16'h8011, 1, 0, 32'h5EED_1234, "R12 crc framing kept");
    chk_err(0, "R12 no error");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule